// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches recently used virtual-to-physical page translations so that a memory access can be mapped without walking the page table. It accepts a 14-bit virtual address and, one clock later, reports whether a cached translation exists. On a hit it also gives the 12-bit physical address. Pages are 64 bytes, so the low six address bits pass through untouched. The eight-bit virtual page number is split: its two low bits pick one of four sets, and its six high bits are the tag compared against the four ways of that set.

Translations enter through a fill port. The page-walk logic outside uses this port after it resolves a miss. A fill takes the lowest-numbered empty way of the target set. When the set is full, a per-set round-robin pointer picks the way to replace. A single flush input empties the whole structure in one cycle. Permission checks, the page walk itself and any data cache are handled elsewhere.

Top module: `xlat_tlb`

## Requirements
- R1: Address split. The offset is lk_va[5:0], the set is lk_va[7:6] and the tag is lk_va[13:8]. For a fill, fill_vpn[1:0] is the set and fill_vpn[7:2] is the tag. A lookup only matches entries in its own set with the same tag.
- R2: A lookup hits only when a valid entry in the selected set holds the same tag. The physical address is then {stored 6-bit page number, lk_va[5:0]}.
- R3: The response is registered. rsp_vld is high in the cycle after lk_req is high. rsp_hit and rsp_pa belong to that request, and rsp_hit is never high without rsp_vld.
- R4: After reset every entry is invalid, rsp_vld and rsp_hit are low, and every lookup misses.
- R5: A fill writes the lowest-numbered invalid way of its set, and that translation hits on later lookups.
- R6: A fill into a full set replaces the way named by that set's round-robin pointer. The pointer starts at 0 after reset or flush and steps by one, modulo 4, after each such replacement.
- R7: A lookup in the same cycle as a fill to its set sees the set as it is after the fill. It hits on the new translation and misses on the one being evicted.
- R8: inv_all empties every entry in one cycle. A lookup in the same cycle misses, and a fill in the same cycle is dropped.
- R9: After filling page 0x0F with page number 0x0D, a lookup of 0x03D4 hits with physical address 0x354.
- R10: Sets are independent. Fills and replacements in one set never remove a translation from another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 14 | Virtual address to translate |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 8 | Virtual page number being installed |
| fill_ppn | input | 6 | Physical page number being installed |
| inv_all | input | 1 | Flush every entry |
| rsp_vld | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 12 | Physical address, meaningful when rsp_hit is high |

## Verification
A lookup and a fill can land on the same set in the same cycle, and the fill may install the page being looked up or evict it. The bench produces this collision in directed steps: it fills a page and looks it up together, and it fills a full set while looking up the victim. The random phase also lets the two coincide freely. In each case the bench reference model applies the fill before it resolves the lookup, and it compares the registered hit flag and address against that result. The same method covers a flush that coincides with a lookup and a fill.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_VA_W  = 14;
  localparam int DEF_OFS_W = 6;
  localparam int DEF_PA_W  = 12;
  localparam int DEF_SET_W = 2;
  localparam int DEF_WAYS  = 4;
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_all,
  input  logic                         wr_en,
  input  logic                         wr_repl,
  input  logic [SET_W-1:0]             wr_set,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [PPN_W-1:0]             wr_ppn,
  output logic [WAYS-1:0]              wr_set_vld,
  output logic [WAY_W-1:0]             wr_set_rr,
  input  logic [SET_W-1:0]             rd_set,
  output logic [WAYS-1:0]              rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][PPN_W-1:0]   rd_ppn
);
  logic [SETS-1:0][WAYS-1:0]              vld_q, vld_d;
  logic [SETS-1:0][WAY_W-1:0]             rr_q, rr_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]   ppn_q;
  logic                                   wr_go;

  assign wr_go = wr_en & ~clr_all;

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (clr_all) begin
      vld_d = '0;
      rr_d  = '0;
    end else if (wr_en) begin
      vld_d[wr_set][wr_way] = 1'b1;
      if (wr_repl) rr_d[wr_set] = rr_q[wr_set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      ppn_q[wr_set][wr_way] <= wr_ppn;
    end
  end

  assign wr_set_vld = vld_q[wr_set];
  assign wr_set_rr  = rr_q[wr_set];
  assign rd_vld     = vld_q[rd_set];
  assign rd_tag     = tag_q[rd_set];
  assign rd_ppn     = ppn_q[rd_set];

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ($countones(vld_q) == 0));

  assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> vld_q[$past(wr_set)][$past(wr_way)]);

  assert_rr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_repl) |=> (rr_q[$past(wr_set)] == WAY_W'($past(wr_set_rr) + 1'b1)));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  set_vld,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim,
  output logic             use_rr
);
  always_comb begin
    victim = rr_ptr;
    use_rr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_vld[w]) begin
        victim = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6
) (
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]  way_ppn,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic                        hit,
  output logic [PPN_W-1:0]            hit_ppn
);
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = way_vld[w] && (way_tag[w] == cmp_tag);
  end

  always_comb begin
    hit     = |way_hit;
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_ppn = way_ppn[w];
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int OFS_W = DEF_OFS_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int SET_W = DEF_SET_W,
  parameter int WAYS  = DEF_WAYS,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int TAG_W = VPN_W - SET_W,
  localparam int PPN_W = PA_W - OFS_W,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_all,
  output logic             rsp_vld,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_pa
);
  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             do_fill, same_set;

  assign lk_set   = lk_va[OFS_W+SET_W-1:OFS_W];
  assign lk_tag   = lk_va[VA_W-1:OFS_W+SET_W];
  assign fill_set = fill_vpn[SET_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:SET_W];
  assign do_fill  = fill_en & ~inv_all;
  assign same_set = do_fill && (fill_set == lk_set);

  logic [WAYS-1:0]            f_vld;
  logic [WAY_W-1:0]           f_rr, vic_way;
  logic                       vic_repl;
  logic [WAYS-1:0]            l_vld, v_vld;
  logic [WAYS-1:0][TAG_W-1:0] l_tag, v_tag;
  logic [WAYS-1:0][PPN_W-1:0] l_ppn, v_ppn;
  logic                       m_hit;
  logic [PPN_W-1:0]           m_ppn;

  xlat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(inv_all),
    .wr_en(do_fill), .wr_repl(vic_repl), .wr_set(fill_set), .wr_way(vic_way),
    .wr_tag(fill_tag), .wr_ppn(fill_ppn),
    .wr_set_vld(f_vld), .wr_set_rr(f_rr),
    .rd_set(lk_set), .rd_vld(l_vld), .rd_tag(l_tag), .rd_ppn(l_ppn)
  );

  xlat_victim #(.WAYS(WAYS)) u_victim (
    .set_vld(f_vld), .rr_ptr(f_rr), .victim(vic_way), .use_rr(vic_repl)
  );

  // Lookup view of its set with a same-cycle fill already applied.
  for (genvar w = 0; w < WAYS; w++) begin : g_view
    logic ovr;
    assign ovr      = same_set && (vic_way == WAY_W'(w));
    assign v_vld[w] = ovr ? 1'b1     : l_vld[w];
    assign v_tag[w] = ovr ? fill_tag : l_tag[w];
    assign v_ppn[w] = ovr ? fill_ppn : l_ppn[w];
  end

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_match (
    .way_vld(v_vld), .way_tag(v_tag), .way_ppn(v_ppn), .cmp_tag(lk_tag),
    .hit(m_hit), .hit_ppn(m_ppn)
  );

  logic            vld_d, hit_d;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    vld_d = lk_req;
    hit_d = lk_req & ~inv_all & m_hit;
    pa_d  = hit_d ? {m_ppn, lk_va[OFS_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_pa  <= '0;
    end else begin
      rsp_vld <= vld_d;
      rsp_hit <= hit_d;
      if (lk_req) rsp_pa <= pa_d;
    end
  end

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_vld);

  assert_hit_needs_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_vld);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!rsp_hit || (rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0]))));

  assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !rsp_hit);
endmodule

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/1ps
module xlat_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [13:0] lk_va;
  logic        fill_en;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic        inv_all;
  logic        rsp_vld, rsp_hit;
  logic [11:0] rsp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlat_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .inv_all(inv_all),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa)
  );

  // Reference model
  bit       m_vld [4][4];
  bit [5:0] m_tag [4][4];
  bit [5:0] m_ppn [4][4];
  bit [1:0] m_rr  [4];

  task automatic m_clear();
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
  endtask

  task automatic m_fill(input bit [7:0] vpn, input bit [5:0] ppn);
    int s = vpn[1:0];
    int v = -1;
    for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) v = w;
    if (v < 0) begin
      v = m_rr[s];
      m_rr[s] = m_rr[s] + 1;
    end
    m_vld[s][v] = 1;
    m_tag[s][v] = vpn[7:2];
    m_ppn[s][v] = ppn;
  endtask

  function automatic bit m_find(input bit [7:0] vpn, output bit [5:0] ppn);
    ppn = 0;
    for (int w = 0; w < 4; w++)
      if (m_vld[vpn[1:0]][w] && m_tag[vpn[1:0]][w] == vpn[7:2]) begin
        ppn = m_ppn[vpn[1:0]][w];
        return 1;
      end
    return 0;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit req, input bit [13:0] va, input bit fe, input bit [7:0] fvpn,
                      input bit [5:0] fppn, input bit inv, input string rq);
    bit       eh = 0;
    bit [5:0] ep = 0;
    @(negedge clk);
    lk_req = req; lk_va = va; fill_en = fe; fill_vpn = fvpn; fill_ppn = fppn; inv_all = inv;
    if (inv) m_clear();
    else begin
      if (fe) m_fill(fvpn, fppn);
      if (req) eh = m_find(va[13:6], ep);
    end
    @(posedge clk);
    #1;
    lk_req = 0; fill_en = 0; inv_all = 0;
    chk("R3", "rsp_vld", rsp_vld, req);
    if (req) begin
      chk(rq, "rsp_hit", rsp_hit, eh);
      if (eh) chk(rq, "rsp_pa", rsp_pa, {ep, va[5:0]});
    end
  endtask

  task automatic look(input bit [13:0] va, input string rq);
    step(1, va, 0, 0, 0, 0, rq);
  endtask

  task automatic fill(input bit [7:0] vpn, input bit [5:0] ppn);
    step(0, 0, 1, vpn, ppn, 0, "R5");
  endtask

  function automatic bit [13:0] va_of(input bit [5:0] tag, input bit [1:0] set, input bit [5:0] ofs);
    return {tag, set, ofs};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    rst_n = 0; lk_req = 0; lk_va = 0; fill_en = 0; fill_vpn = 0; fill_ppn = 0; inv_all = 0;
    m_clear();
    repeat (3) @(posedge clk);
    #1;
    chk("R4", "rsp_vld in reset", rsp_vld, 0);
    chk("R4", "rsp_hit in reset", rsp_hit, 0);
    @(negedge clk); rst_n = 1;

    // R4: empty after reset
    look(14'h03D4, "R4");
    look(14'h0000, "R4");

    // R9: worked example, R1 neighbours with other set or other tag miss
    fill(8'h0F, 6'h0D);
    look(14'h03D4, "R9");
    chk("R9", "example pa", rsp_pa, 12'h354);
    look(va_of(6'h04, 2'd3, 6'h14), "R1");
    look(va_of(6'h03, 2'd2, 6'h14), "R1");
    look(va_of(6'h03, 2'd3, 6'h3F), "R2");

    // R5/R6: fill set 1 full then replace in round-robin order
    step(0, 0, 0, 0, 0, 1, "R8");
    fill({6'h01, 2'd2}, 6'h21);   // R10 bystander in set 2
    for (int i = 0; i < 4; i++) fill({6'(8 + i), 2'd1}, 6'(16 + i));
    for (int i = 0; i < 4; i++) look(va_of(6'(8 + i), 2'd1, 6'(i)), "R5");
    fill({6'h20, 2'd1}, 6'h30);
    look(va_of(6'h08, 2'd1, 0), "R6");
    look(va_of(6'h09, 2'd1, 0), "R6");
    fill({6'h21, 2'd1}, 6'h31);
    look(va_of(6'h09, 2'd1, 0), "R6");
    look(va_of(6'h20, 2'd1, 5), "R6");
    look(va_of(6'h01, 2'd2, 7), "R10");

    // R7: fill and lookup of the same page together, and eviction of the looked-up page
    step(1, va_of(6'h22, 2'd1, 9), 1, {6'h22, 2'd1}, 6'h32, 0, "R7");
    step(1, va_of(6'h0B, 2'd1, 9), 1, {6'h23, 2'd1}, 6'h33, 0, "R7");
    look(va_of(6'h23, 2'd1, 1), "R7");

    // R8: flush with lookup and fill in the same cycle, then pointer restart
    step(1, va_of(6'h23, 2'd1, 1), 1, {6'h24, 2'd1}, 6'h34, 1, "R8");
    look(va_of(6'h24, 2'd1, 1), "R8");
    look(va_of(6'h01, 2'd2, 7), "R8");
    for (int i = 0; i < 5; i++) fill({6'(40 + i), 2'd0}, 6'(i));
    look(va_of(6'd40, 2'd0, 0), "R6");
    look(va_of(6'd41, 2'd0, 0), "R6");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit       rq  = ($urandom_range(0, 3) != 0);
      bit       fe  = ($urandom_range(0, 9) < 3);
      bit       inv = ($urandom_range(0, 199) == 0);
      bit [1:0] fs  = 2'($urandom_range(0, 3));
      bit [5:0] ft  = 6'($urandom_range(0, 7));
      bit [1:0] ls  = 2'($urandom_range(0, 3));
      bit [5:0] lt  = 6'($urandom_range(0, 7));
      bit [5:0] dummy;
      if (m_find({ft, fs}, dummy)) fe = 0;
      step(rq, va_of(lt, ls, 6'($urandom)), fe, {ft, fs}, 6'($urandom), inv, "R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule